// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Sequencer

This block owns a shared clock-stop vector and a shared reset-hold vector for a group of peripherals. Each channel maps to one stop bit and, if it has one, one reset bit. A set stop bit keeps that peripheral's clock halted. A set reset bit keeps the peripheral in reset.

A requester presents a channel number and an on/off command on a valid/ready port. Switching on a channel that has a reset line runs a timed sequence:

1. Hold the peripheral in reset.
2. Wait a settling interval.
3. Let the clock run.
4. Wait a longer interval.
5. Free the peripheral from reset.

A channel without a reset line, and every switch-off, completes in the cycle after acceptance. Only one request is processed at a time.

Both intervals are given in microseconds. They are turned into cycle counts using the reference clock frequency parameter in MHz, so the same block serves any clock rate. A per-channel status output shows which clocks are running.

Top module: `clk_reset_seq`

## Requirements
- R1: After power-on reset, every bit of `clk_stop` and `rst_hold` is 1, `req_ready` is 1, `busy` and `done` are 0, and `chan_on` is all zeros.
- R2: Accepting a switch-on for a channel with a reset line sets that channel's `rst_hold` bit in the next cycle. The channel's `clk_stop` bit keeps its previous value for exactly PRE_CYC cycles after acceptance and is cleared on the PRE_CYC-th edge.
- R3: In that sequence, the channel's `rst_hold` bit is cleared POST_CYC cycles after the stop bit was cleared. `done` is 1 in that same cycle and only then.
- R4: Accepting a switch-on for a channel without a reset line clears its `clk_stop` bit in the next cycle, with `done` high in that cycle. `rst_hold` is not changed.
- R5: Accepting a switch-off (`req_on` = 0) sets the channel's `clk_stop` bit in the next cycle, with `done` high in that cycle. `rst_hold` is left unchanged.
- R6: `chan_on[i]` equals the inverse of the `clk_stop` bit mapped to channel i.
- R7: While a timed sequence runs, `busy` is 1 and `req_ready` is 0. A request presented then is not accepted and changes no bit of `clk_stop` or `rst_hold`.
- R8: Any single cycle changes at most one bit of `clk_stop` and at most one bit of `rst_hold`. Bits of channels other than the one addressed are never changed.
- R9: PRE_CYC = PRE_US × REF_MHZ and POST_CYC = POST_US × REF_MHZ, with a product of zero raised to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_chan | input | CH_W | Channel number addressed |
| req_on | input | 1 | 1 = switch on, 0 = switch off |
| busy | output | 1 | Timed sequence in progress |
| done | output | 1 | One-cycle completion marker |
| clk_stop | output | STOP_W | Clock-stop vector, 1 = clock halted |
| rst_hold | output | RST_W | Reset vector, 1 = peripheral held in reset |
| chan_on | output | NUM_CH | Per-channel clock running status |

## Verification
The assertions assume that the channel map gives distinct, in-range stop bits and distinct reset bits to the channels that use them. They also assume that `rst_n` is held low from time zero until the first edges. The bench's small configuration fulfils both: four channels, one of them without a reset line, with stop indices scattered over a six-bit vector. It also changes all inputs on falling edges only. Requests raised during a busy sequence are withdrawn before the sequence ends, so the invisible-request rule can be observed on the output vectors.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  // Delay in cycles for a span in microseconds at a reference rate in MHz.
  function automatic int unsigned span_cycles(int unsigned us, int unsigned mhz);
    int unsigned c;
    c = us * mhz;
    return (c == 0) ? 1 : c;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned bits_for(int unsigned v);
    return (v <= 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/cgr_chan_map.sv
module cgr_chan_map #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned SI_W   = 3,
  parameter int unsigned RI_W   = 3,
  parameter int unsigned STOP_IDX [NUM_CH] = '{0, 1, 2, 3},
  parameter int unsigned RST_IDX  [NUM_CH] = '{0, 1, 2, 3},
  parameter logic [NUM_CH-1:0] HAS_RST = '1
) (
  input  logic [CH_W-1:0] chan,
  output logic [SI_W-1:0] stop_idx,
  output logic [RI_W-1:0] rst_idx,
  output logic            has_rst,
  output logic            in_range
);

  always_comb begin
    stop_idx = '0;
    rst_idx  = '0;
    has_rst  = 1'b0;
    in_range = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan == CH_W'(i)) begin
        stop_idx = SI_W'(STOP_IDX[i]);
        rst_idx  = RI_W'(RST_IDX[i]);
        has_rst  = HAS_RST[i];
        in_range = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cgr_wait_timer.sv
module cgr_wait_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MAX_VAL = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             at_zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);

  // R9: a loaded count never exceeds the longest configured wait
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_VAL));

  // R9: without a reload the count only steps down by one
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/clk_reset_seq.sv
module clk_reset_seq
  import cgr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned STOP_W  = 8,
  parameter int unsigned RST_W   = 8,
  parameter int unsigned REF_MHZ = 125,
  parameter int unsigned PRE_US  = 100,
  parameter int unsigned POST_US = 10000,
  parameter int unsigned STOP_IDX [NUM_CH] = '{0, 1, 2, 3},
  parameter int unsigned RST_IDX  [NUM_CH] = '{0, 1, 2, 3},
  parameter logic [NUM_CH-1:0] HAS_RST = '1,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic              req_on,
  output logic              busy,
  output logic              done,
  output logic [STOP_W-1:0] clk_stop,
  output logic [RST_W-1:0]  rst_hold,
  output logic [NUM_CH-1:0] chan_on
);

  localparam int unsigned PRE_CYC  = span_cycles(PRE_US, REF_MHZ);
  localparam int unsigned POST_CYC = span_cycles(POST_US, REF_MHZ);
  localparam int unsigned MAX_CYC  = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int unsigned CNT_W    = bits_for(MAX_CYC - 1);
  localparam int unsigned SI_W     = bits_for(STOP_W - 1);
  localparam int unsigned RI_W     = bits_for(RST_W - 1);

  seq_state_e        state_q;
  logic [STOP_W-1:0] stop_q;
  logic [RST_W-1:0]  rst_q;
  logic              done_q;
  logic [SI_W-1:0]   cur_stop_q;
  logic [RI_W-1:0]   cur_rst_q;

  logic [SI_W-1:0]   m_stop;
  logic [RI_W-1:0]   m_rst;
  logic              m_has_rst;
  logic              m_ok;
  logic              t_zero;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;

  // Named internal events
  logic ev_accept;
  logic ev_start_seq;
  logic ev_ungate;
  logic ev_release;

  cgr_chan_map #(
    .NUM_CH  (NUM_CH),
    .CH_W    (CH_W),
    .SI_W    (SI_W),
    .RI_W    (RI_W),
    .STOP_IDX(STOP_IDX),
    .RST_IDX (RST_IDX),
    .HAS_RST (HAS_RST)
  ) u_map (
    .chan    (req_chan),
    .stop_idx(m_stop),
    .rst_idx (m_rst),
    .has_rst (m_has_rst),
    .in_range(m_ok)
  );

  assign req_ready    = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign clk_stop     = stop_q;
  assign rst_hold     = rst_q;

  assign ev_accept    = req_valid && req_ready;
  assign ev_start_seq = ev_accept && req_on && m_ok && m_has_rst;
  assign ev_ungate    = (state_q == ST_HOLD) && t_zero;
  assign ev_release   = (state_q == ST_RUN) && t_zero;

  assign t_load = ev_start_seq || ev_ungate;
  assign t_val  = ev_ungate ? CNT_W'(POST_CYC - 1) : CNT_W'(PRE_CYC - 1);

  cgr_wait_timer #(
    .CNT_W  (CNT_W),
    .MAX_VAL(MAX_CYC - 1)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_val(t_val),
    .at_zero (t_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      stop_q     <= '1;
      rst_q      <= '1;
      done_q     <= 1'b0;
      cur_stop_q <= '0;
      cur_rst_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ev_accept) begin
            if (!m_ok) begin
              done_q <= 1'b1;
            end else if (!req_on) begin
              stop_q[m_stop] <= 1'b1;
              done_q         <= 1'b1;
            end else if (!m_has_rst) begin
              stop_q[m_stop] <= 1'b0;
              done_q         <= 1'b1;
            end else begin
              rst_q[m_rst] <= 1'b1;
              cur_stop_q   <= m_stop;
              cur_rst_q    <= m_rst;
              state_q      <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (t_zero) begin
            stop_q[cur_stop_q] <= 1'b0;
            state_q            <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (t_zero) begin
            rst_q[cur_rst_q] <= 1'b0;
            done_q           <= 1'b1;
            state_q          <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_status
    assign chan_on[g] = ~stop_q[STOP_IDX[g]];
  end

  // R5: switching off leaves every reset bit as it was
  p_off_keeps_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !req_on) |=> $stable(rst_q));

  // R8: at most one stop bit and one reset bit move per cycle
  p_one_stop_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stop_q ^ $past(stop_q)) <= 1);
  p_one_rst_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rst_q ^ $past(rst_q)) <= 1);

  // R2: the clock is only let run while its peripheral is held in reset
  p_ungate_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ungate |-> rst_q[cur_rst_q]);

  // R3: reset is freed only once the clock already runs
  p_release_clock_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |-> !stop_q[cur_stop_q]);

  // R7: completion is reported only when idle again
  p_done_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !busy));

  // R7: a running sequence keeps the clock bit still while it holds reset
  p_hold_clock_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !t_zero) |=> $stable(stop_q));

endmodule

// File: tb/clk_reset_seq_tb.sv
module clk_reset_seq_tb;

  localparam int unsigned NCH  = 4;
  localparam int unsigned SW   = 6;
  localparam int unsigned RW   = 4;
  localparam int unsigned MHZ  = 2;
  localparam int unsigned PUS  = 3;
  localparam int unsigned QUS  = 4;
  localparam int unsigned PRE  = PUS * MHZ;
  localparam int unsigned POST = QUS * MHZ;
  localparam int unsigned SIDX [NCH] = '{5, 1, 3, 0};
  localparam int unsigned RIDX [NCH] = '{2, 0, 0, 3};
  localparam logic [NCH-1:0] HASR = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_chan = '0;
  logic req_on = 1'b0;
  logic busy, done;
  logic [SW-1:0] clk_stop;
  logic [RW-1:0] rst_hold;
  logic [NCH-1:0] chan_on;

  int n_checks = 0;
  int n_fail = 0;
  logic [SW-1:0] e_stop;
  logic [RW-1:0] e_rst;

  always #4 clk = ~clk;

  clk_reset_seq #(
    .NUM_CH(NCH), .STOP_W(SW), .RST_W(RW), .REF_MHZ(MHZ),
    .PRE_US(PUS), .POST_US(QUS),
    .STOP_IDX(SIDX), .RST_IDX(RIDX), .HAS_RST(HASR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_on(req_on), .busy(busy), .done(done),
    .clk_stop(clk_stop), .rst_hold(rst_hold), .chan_on(chan_on)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] exp_on(logic [SW-1:0] s);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = !s[SIDX[i]];
    return r;
  endfunction

  task automatic check_all(string tag, logic e_done, logic e_busy);
    check({tag, " R8 clk_stop"}, 32'(clk_stop), 32'(e_stop));
    check({tag, " R8 rst_hold"}, 32'(rst_hold), 32'(e_rst));
    check({tag, " R6 chan_on"}, 32'(chan_on), 32'(exp_on(e_stop)));
    check({tag, " done"}, 32'(done), 32'(e_done));
    check({tag, " R7 busy"}, 32'(busy), 32'(e_busy));
    check({tag, " R7 ready"}, 32'(req_ready), 32'(!e_busy));
  endtask

  // Present one request; returns at the falling edge after its acceptance.
  task automatic issue(int ch, logic on);
    @(negedge clk);
    req_valid = 1'b1;
    req_chan  = 2'(ch);
    req_on    = on;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // intr >= 0: channel to offer a switch-off while the sequence is busy
  task automatic run_on(int ch, int intr);
    issue(ch, 1'b1);
    if (!HASR[ch]) begin
      e_stop[SIDX[ch]] = 1'b0;
      check_all("R4", 1'b1, 1'b0);
    end else begin
      for (int k = 0; k <= int'(PRE + POST); k++) begin
        if (k == 0) e_rst[RIDX[ch]] = 1'b1;
        if (k == int'(PRE)) e_stop[SIDX[ch]] = 1'b0;
        if (k == int'(PRE + POST)) e_rst[RIDX[ch]] = 1'b0;
        check_all((k < int'(PRE)) ? "R2 R9" : "R3 R9",
                  k == int'(PRE + POST), k < int'(PRE + POST));
        if (intr >= 0 && k == 2) begin
          req_valid = 1'b1;
          req_chan  = 2'(intr);
          req_on    = 1'b0;
        end
        if (k == 4) req_valid = 1'b0;
        if (k < int'(PRE + POST)) @(negedge clk);
      end
    end
  endtask

  task automatic run_off(int ch);
    issue(ch, 1'b0);
    e_stop[SIDX[ch]] = 1'b1;
    check_all("R5", 1'b1, 1'b0);
  endtask

  initial begin
    e_stop = '1;
    e_rst  = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", 1'b0, 1'b0);
    check("R1 chan_on zero", 32'(chan_on), 32'h0);

    // Switch on every channel in turn; intrude on channel 0 while channel 1 runs
    run_on(0, -1);
    run_on(1, 0);
    run_on(2, -1);
    run_on(3, 2);

    // Switch-offs leave reset alone
    run_off(1);
    run_off(2);
    run_off(0);

    // Re-enable: a stopped channel with reset freed, a running one, a resetless one
    run_on(1, 3);
    run_on(3, -1);
    run_on(2, -1);
    run_on(2, -1);

    // Back-to-back switch-offs of all channels
    for (int c = 0; c < int'(NCH); c++) run_off(c);
    run_off(0);

    @(negedge clk);
    check_all("R5 idle", 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule